// File: doc/BRIEF.md
# Descriptor Completion Notifier

This block handles the closing phase of a single crypto channel's work on one descriptor. When the execution units report that they have finished, it asks for the results to be unloaded. Once the unload is acknowledged, it does one of two things. If another service is still pending, it hands control back to service dispatch. If not, it releases the execution units and then reports completion in whatever way the channel is configured to use.

Completion is reported through a host-memory writeback of the descriptor header, through a single-cycle interrupt, or through both. The written-back header is the fetched header with its DONE field forced to all ones. It can also carry the two-bit outcome of the integrity-check-value comparison. Reporting is enabled either for every descriptor or only for descriptors whose header sets a request flag. A sticky status word keeps a record of the most recent completion until software clears it.

Top module: `desc_done_notifier`

## Requirements
- R1: While reset is held, and in the first cycle after it, `unload_req`, `dispatch`, `eu_release`, `wr_valid` and `irq` are 0 and `stat` is 0.
- R2: A cycle with `eu_done` high raises `unload_req` from the next cycle on. It stays high until a cycle with `unload_ack` high.
- R3: If `more_svc` is high in the `unload_ack` cycle, `dispatch` pulses for one cycle in the following cycle. In that case there is no `eu_release`, no writeback and no `irq`.
- R4: If `more_svc` is low in the `unload_ack` cycle, `eu_release` pulses for exactly one cycle in the following cycle.
- R5: Notification is enabled when `cfg_notify_all` is 1 or header bit 63 is 1. When it is disabled, neither a writeback nor an `irq` follows the release.
- R6: With notification enabled and `cfg_wb_en` set, `wr_valid` rises in the cycle after `eu_release`. `wr_addr` equals `hdr_addr`. `wr_data` equals the header with bits [7:0] forced to 1 and, unless R7 applies, every other bit unchanged.
- R7: With `cfg_icv_wb` set, bits [9:8] of `wr_data` carry `icv_st`, encoded as 00 = not checked, 01 = pass, 10 = fail, 11 = reserved. With `cfg_icv_wb` clear, bits [9:8] keep the header's value.
- R8: While `wr_valid` is high and `wr_ready` is low, `wr_valid`, `wr_addr` and `wr_data` hold steady.
- R9: `irq` is a one-cycle pulse, and only when notification and `cfg_irq_en` are both on. With a writeback it comes in the cycle after the write is accepted. Without a writeback it comes in the cycle after `eu_release`.
- R10: From the cycle after `eu_release`, `stat` = {`icv_st`, notification-enabled, 1}. A `stat_clr` pulse zeroes it. A release in the same cycle wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| eu_done | input | 1 | Execution units have finished the current service |
| unload_ack | input | 1 | Result unload complete |
| more_svc | input | 1 | Descriptor still has services pending |
| hdr_i | input | 64 | Captured descriptor header |
| hdr_addr | input | 32 | Host address of the header |
| icv_st | input | 2 | Integrity check outcome |
| cfg_notify_all | input | 1 | Notify on every descriptor |
| cfg_wb_en | input | 1 | Enable header writeback |
| cfg_irq_en | input | 1 | Enable completion interrupt |
| cfg_icv_wb | input | 1 | Include check outcome in writeback |
| stat_clr | input | 1 | Write-one-to-clear for status |
| unload_req | output | 1 | Request result unload |
| dispatch | output | 1 | Return to service dispatch |
| eu_release | output | 1 | Release the execution units |
| wr_valid | output | 1 | Writeback request valid |
| wr_ready | input | 1 | Writeback accepted |
| wr_addr | output | 32 | Writeback address |
| wr_data | output | 64 | Writeback header |
| irq | output | 1 | Completion interrupt pulse |
| stat | output | 4 | Sticky completion status |

## Verification
The bench drives a descriptor that still has services pending. A design that took the wrong branch there would release the units or notify too early. It runs descriptors with the header flag both clear and set while the global enable is off, which catches a notify gate that ignores either source. Writeback data is compared bit for bit with and without the check outcome included, so a DONE mask or check field placed at the wrong bits shows up as a data mismatch. The bench also holds `wr_ready` low for several cycles, exposing an interrupt fired before acceptance or a request that drops or changes early.

// File: rtl/desc_done_notifier.sv
module desc_done_notifier #(
  parameter int HDR_W    = 64,
  parameter int ADDR_W   = 32,
  parameter int DONE_LSB = 0,
  parameter int DONE_W   = 8,
  parameter int ICV_LSB  = 8,
  parameter int NOTE_BIT = 63
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              eu_done,
  input  logic              unload_ack,
  input  logic              more_svc,
  input  logic [HDR_W-1:0]  hdr_i,
  input  logic [ADDR_W-1:0] hdr_addr,
  input  logic [1:0]        icv_st,
  input  logic              cfg_notify_all,
  input  logic              cfg_wb_en,
  input  logic              cfg_irq_en,
  input  logic              cfg_icv_wb,
  input  logic              stat_clr,
  output logic              unload_req,
  output logic              dispatch,
  output logic              eu_release,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [HDR_W-1:0]  wr_data,
  output logic              irq,
  output logic [3:0]        stat
);
  localparam int ICV_W = 2;
  localparam logic [HDR_W-1:0] DONE_MASK =
    {{(HDR_W-DONE_W){1'b0}}, {DONE_W{1'b1}}} << DONE_LSB;
  localparam logic [HDR_W-1:0] ICV_MASK =
    {{(HDR_W-ICV_W){1'b0}}, {ICV_W{1'b1}}} << ICV_LSB;

  typedef enum logic [2:0] {S_IDLE, S_UNLOAD, S_DISP, S_REL, S_WB, S_IRQ} st_t;
  st_t st, st_n;

  logic             notify;
  logic [HDR_W-1:0] wb_hdr, wb_q;
  logic [ADDR_W-1:0] addr_q;
  logic             irq_after_wb;

  assign notify = cfg_notify_all | hdr_i[NOTE_BIT];

  always_comb begin
    wb_hdr = hdr_i | DONE_MASK;
    if (cfg_icv_wb)
      wb_hdr = (wb_hdr & ~ICV_MASK) |
               ({{(HDR_W-ICV_W){1'b0}}, icv_st} << ICV_LSB);
  end

  always_comb begin
    st_n = st;
    case (st)
      S_IDLE:   if (eu_done) st_n = S_UNLOAD;
      S_UNLOAD: if (unload_ack) st_n = more_svc ? S_DISP : S_REL;
      S_DISP:   st_n = S_IDLE;
      S_REL:    if (notify && cfg_wb_en) st_n = S_WB;
                else if (notify && cfg_irq_en) st_n = S_IRQ;
                else st_n = S_IDLE;
      S_WB:     if (wr_ready) st_n = irq_after_wb ? S_IRQ : S_IDLE;
      S_IRQ:    st_n = S_IDLE;
      default:  st_n = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st           <= S_IDLE;
      wb_q         <= '0;
      addr_q       <= '0;
      irq_after_wb <= 1'b0;
      stat         <= '0;
    end else begin
      st <= st_n;
      if (st == S_REL) begin
        wb_q         <= wb_hdr;
        addr_q       <= hdr_addr;
        irq_after_wb <= notify & cfg_irq_en;
        stat         <= {icv_st, notify, 1'b1};
      end else if (stat_clr) begin
        stat <= '0;
      end
    end
  end

  assign unload_req = (st == S_UNLOAD);
  assign dispatch   = (st == S_DISP);
  assign eu_release = (st == S_REL);
  assign wr_valid   = (st == S_WB);
  assign irq        = (st == S_IRQ);
  assign wr_data    = wb_q;
  assign wr_addr    = addr_q;
endmodule

// File: rtl/desc_done_notifier_chk.sv
module desc_done_notifier_chk #(
  parameter int HDR_W    = 64,
  parameter int ADDR_W   = 32,
  parameter int DONE_LSB = 0,
  parameter int DONE_W   = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              unload_ack,
  input logic              more_svc,
  input logic              unload_req,
  input logic              dispatch,
  input logic              eu_release,
  input logic              wr_valid,
  input logic              wr_ready,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [HDR_W-1:0]  wr_data,
  input logic              irq,
  input logic [3:0]        stat
);
  // R3
  dispatch_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dispatch |-> $past(unload_req && unload_ack && more_svc));
  // R4
  release_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eu_release |-> $past(unload_req && unload_ack && !more_svc));
  // R6
  done_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> &wr_data[DONE_LSB +: DONE_W]);
  // R8
  wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_data) && $stable(wr_addr)));
  // R9
  irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);
  // R10
  stat_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eu_release |=> stat[0]);
  // R4
  single_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({unload_req, dispatch, eu_release, wr_valid, irq}));
endmodule

bind desc_done_notifier desc_done_notifier_chk #(
  .HDR_W(HDR_W), .ADDR_W(ADDR_W), .DONE_LSB(DONE_LSB), .DONE_W(DONE_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .unload_ack(unload_ack), .more_svc(more_svc),
  .unload_req(unload_req), .dispatch(dispatch), .eu_release(eu_release),
  .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr),
  .wr_data(wr_data), .irq(irq), .stat(stat)
);

// File: tb/tb_desc_done_notifier.sv
`timescale 1ns/1ps
module tb_desc_done_notifier;
  logic clk = 0, rst_n = 0;
  logic eu_done = 0, unload_ack = 0, more_svc = 0;
  logic [63:0] hdr_i = '0;
  logic [31:0] hdr_addr = '0;
  logic [1:0] icv_st = '0;
  logic cfg_notify_all = 0, cfg_wb_en = 0, cfg_irq_en = 0, cfg_icv_wb = 0;
  logic stat_clr = 0, wr_ready = 1;
  logic unload_req, dispatch, eu_release, wr_valid, irq;
  logic [31:0] wr_addr;
  logic [63:0] wr_data;
  logic [3:0] stat;

  desc_done_notifier dut (.*);

  always #2.5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0, n_bad = 0;
  int n_disp, n_rel, n_acc, n_irq, rel_cyc, acc_cyc, irq_cyc, wv_cyc;
  logic [63:0] acc_data;
  logic [31:0] acc_addr;

  always @(negedge clk) if (rst_n) begin
    if (dispatch) n_disp++;
    if (eu_release) begin n_rel++; rel_cyc = cyc; end
    if (wr_valid) begin
      if (wv_cyc < 0) wv_cyc = cyc;
      if (wr_ready) begin n_acc++; acc_cyc = cyc; acc_data = wr_data; acc_addr = wr_addr; end
    end
    if (irq) begin n_irq++; irq_cyc = cyc; end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic tick(); @(posedge clk); #1; endtask

  task automatic clr_mon();
    n_disp = 0; n_rel = 0; n_acc = 0; n_irq = 0;
    rel_cyc = -1; acc_cyc = -1; irq_cyc = -1; wv_cyc = -1;
  endtask

  task automatic run_desc(input logic more, input int ready_hold);
    clr_mon();
    eu_done = 1; tick(); eu_done = 0;
    chk(unload_req === 1'b1, "R2", "unload_req after done", unload_req, 1);
    tick();
    chk(unload_req === 1'b1, "R2", "unload_req held", unload_req, 1);
    more_svc = more; unload_ack = 1;
    if (ready_hold > 0) wr_ready = 0;
    tick(); unload_ack = 0; more_svc = 0;
    if (ready_hold > 0) begin
      tick();
      chk(wr_valid === 1'b1, "R6", "wr_valid raised", wr_valid, 1);
      for (int i = 0; i < ready_hold; i++) begin
        logic [63:0] d; d = wr_data;
        tick();
        chk(wr_valid === 1'b1 && wr_data === d, "R8", "held under backpressure", wr_data, d);
        chk(irq === 1'b0, "R9", "no irq before accept", irq, 0);
      end
      wr_ready = 1;
    end
    repeat (6) tick();
  endtask

  function automatic logic [63:0] exp_wb(input logic [63:0] h, input logic icv_on,
                                         input logic [1:0] icv);
    logic [63:0] e; e = h; e[7:0] = 8'hFF;
    if (icv_on) e[9:8] = icv;
    return e;
  endfunction

  task automatic t_reset();
    chk({unload_req, dispatch, eu_release, wr_valid, irq} === 5'b0, "R1", "outputs in reset",
        {unload_req, dispatch, eu_release, wr_valid, irq}, 0);
    rst_n = 1; tick();
    chk({unload_req, dispatch, eu_release, wr_valid, irq} === 5'b0 && stat === 4'b0, "R1",
        "outputs after reset", {stat, unload_req, dispatch, eu_release, wr_valid, irq}, 0);
  endtask

  task automatic t_more();
    cfg_notify_all = 1; cfg_wb_en = 1; cfg_irq_en = 1;
    hdr_i = 64'h0123_4567_89AB_CD00;
    run_desc(1, 0);
    chk(n_disp == 1, "R3", "dispatch count", n_disp, 1);
    chk(n_rel == 0 && n_acc == 0 && n_irq == 0, "R3", "no release/notify",
        {n_rel[15:0], n_acc[15:0], n_irq[15:0]}, 0);
  endtask

  task automatic t_wb_irq();
    cfg_notify_all = 1; cfg_wb_en = 1; cfg_irq_en = 1; cfg_icv_wb = 0;
    hdr_i = 64'h0123_4567_89AB_CE12; hdr_addr = 32'h8000_1040; icv_st = 2'b10;
    run_desc(0, 0);
    chk(n_rel == 1, "R4", "release count", n_rel, 1);
    chk(wv_cyc == rel_cyc + 1, "R6", "wr_valid timing", wv_cyc, rel_cyc + 1);
    chk(acc_data === exp_wb(hdr_i, 0, 0), "R7", "data w/o icv keeps bits", acc_data, exp_wb(hdr_i, 0, 0));
    chk(acc_addr === hdr_addr, "R6", "wr_addr", acc_addr, hdr_addr);
    chk(n_irq == 1 && irq_cyc == acc_cyc + 1, "R9", "irq after accept", irq_cyc, acc_cyc + 1);
    chk(stat === 4'b1011, "R10", "stat after completion", stat, 4'b1011);
  endtask

  task automatic t_icv();
    cfg_icv_wb = 1; cfg_irq_en = 0;
    hdr_i = 64'hFEDC_BA98_7654_0300; icv_st = 2'b01;
    run_desc(0, 0);
    chk(acc_data === exp_wb(hdr_i, 1, 2'b01), "R7", "icv pass in data", acc_data, exp_wb(hdr_i, 1, 2'b01));
    chk(n_irq == 0, "R9", "no irq when disabled", n_irq, 0);
    icv_st = 2'b10; hdr_i = 64'h1111_2222_3333_4455;
    run_desc(0, 0);
    chk(acc_data === exp_wb(hdr_i, 1, 2'b10), "R7", "icv fail in data", acc_data, exp_wb(hdr_i, 1, 2'b10));
    cfg_icv_wb = 0;
  endtask

  task automatic t_flag();
    cfg_notify_all = 0; cfg_wb_en = 1; cfg_irq_en = 1;
    hdr_i = 64'h7000_0000_0000_0001;
    run_desc(0, 0);
    chk(n_rel == 1, "R4", "release without notify", n_rel, 1);
    chk(n_acc == 0 && n_irq == 0, "R5", "flag clear silent", {n_acc[15:0], n_irq[15:0]}, 0);
    chk(stat === 4'b1001, "R10", "stat notify bit clear", stat, 4'b1001);
    hdr_i = 64'h8000_0000_0000_0001;
    run_desc(0, 0);
    chk(n_acc == 1 && n_irq == 1, "R5", "flag set notifies", {n_acc[15:0], n_irq[15:0]}, 32'h0001_0001);
  endtask

  task automatic t_irq_only();
    cfg_notify_all = 1; cfg_wb_en = 0; cfg_irq_en = 1;
    run_desc(0, 0);
    chk(n_acc == 0, "R9", "no write", n_acc, 0);
    chk(n_irq == 1 && irq_cyc == rel_cyc + 1, "R9", "irq after release", irq_cyc, rel_cyc + 1);
  endtask

  task automatic t_backpressure();
    cfg_notify_all = 1; cfg_wb_en = 1; cfg_irq_en = 1;
    hdr_i = 64'hA5A5_5A5A_0F0F_F000;
    run_desc(0, 3);
    chk(n_acc == 1 && irq_cyc == acc_cyc + 1, "R9", "irq after late accept", irq_cyc, acc_cyc + 1);
  endtask

  task automatic t_clear();
    chk(stat[0] === 1'b1, "R10", "stat before clear", stat, 1);
    stat_clr = 1; tick(); stat_clr = 0;
    chk(stat === 4'b0, "R10", "stat cleared", stat, 0);
  endtask

  initial begin
    fork
      begin
        clr_mon();
        repeat (3) tick();
        t_reset();
        t_more();
        t_wb_irq();
        t_icv();
        t_flag();
        t_irq_only();
        t_backpressure();
        t_clear();
      end
      begin
        repeat (20000) @(posedge clk);
        chk(0, "WDOG", "watchdog expired", 0, 1);
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule